// File: doc/BRIEF.md
# Endpoint Buffer Descriptor Engine

This block serves the buffer descriptor of a single USB endpoint. The CPU fills the descriptor with a status word, a buffer start address and a 10-bit byte count. It then sets the ownership bit to hand the descriptor to the engine. When the packet layer presents a token, the engine checks ownership, the stall request and the data toggle, and from these it chooses a response: ACK, NAK, STALL or silence.

On an accepted OUT or SETUP packet, the engine writes the payload into the buffer memory through a working pointer. On an accepted IN token, it reads the payload from the buffer memory and streams it out. When the transaction ends, the engine either returns the descriptor to the CPU with the received toggle, the token kind and the actual byte count recorded, or it keeps the descriptor untouched for the next token.

The CPU reads and writes the buffer memory through its own port. Status word bits: bit 0 owned by engine, bit 1 data toggle (1 = DATA1), bit 2 toggle check enable, bit 3 stall request, bit 4 keep descriptor, bit 5 address increment disable. Token kinds: 0 OUT, 1 IN, 2 SETUP. Response codes: 0 ACK, 1 NAK, 2 STALL, 3 none.

Top module: `ep_desc_engine`

## Requirements
- R1: After reset the status word, byte count, address, last token kind and overflow flag read 0, and neither hsValid nor txValid is asserted.
- R2: With ownership bit 0, an OUT token is answered NAK (code 1) after its data, and an IN token is answered NAK with no bytes sent. Neither writes the buffer memory or changes the descriptor.
- R3: An owned, accepted OUT packet writes its bytes into consecutive buffer addresses from the programmed address and is answered ACK (code 0) one cycle after rxEnd.
- R4: On handback after an accepted OUT or SETUP packet, the ownership bit clears, the toggle bit takes the received toggle, the byte count takes the number of bytes stored, and lastPid shows the token kind.
- R5: With toggle check enabled (bit 2), an OUT packet whose toggle differs from bit 1 gets no response (code 3). Nothing is written and the descriptor is unchanged, so ownership stays 1.
- R6: A SETUP packet (kind 2) is accepted even when toggle check is enabled and its toggle differs from bit 1.
- R7: With toggle check disabled, an OUT packet with either toggle value is accepted.
- R8: With the stall bit set on an owned descriptor, OUT and IN tokens are answered STALL (code 2). No byte moves, ownership stays 1 and no descriptor field changes.
- R9: With the keep bit set, an accepted packet is answered ACK and the descriptor stays owned with all fields unchanged, so a further token is again served.
- R10: With increment disable set, every byte of a transfer uses the programmed address: an OUT leaves the last byte there, and an IN sends the byte stored there repeatedly.
- R11: An owned IN token sends exactly byte-count bytes from the buffer, with txLast on the final byte and txToggle equal to bit 1, then answers ACK. Handback clears ownership, sets lastPid to 1 and keeps the count. A count of 0 sends no bytes.
- R12: An accepted OUT packet longer than the byte count stores only the first byte-count bytes and sets ovfOut. ovfOut clears at the next token.
- R13: hsValid is a single-cycle pulse, raised exactly once per OUT, SETUP or IN token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWe | input | 1 | Load status word, address and byte count |
| cpuStat | input | 6 | Status word to load |
| cpuAddr | input | AW | Buffer start address to load |
| cpuCnt | input | 10 | Byte count to load |
| statOut | output | 6 | Current status word |
| addrOut | output | AW | Programmed buffer address |
| cntOut | output | 10 | Current byte count |
| lastPid | output | 2 | Kind of the last token that caused a handback |
| ovfOut | output | 1 | Last OUT packet exceeded the byte count |
| cpuMemWe | input | 1 | CPU write strobe for the buffer memory |
| cpuMemAddr | input | AW | CPU buffer memory address |
| cpuMemWdata | input | 8 | CPU buffer write data |
| cpuMemRdata | output | 8 | CPU buffer read data (combinational) |
| tokValid | input | 1 | Token present |
| tokKind | input | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP |
| tokToggle | input | 1 | Toggle of the data packet that follows an OUT or SETUP |
| rxValid | input | 1 | Received payload byte valid |
| rxByte | input | 8 | Received payload byte |
| rxEnd | input | 1 | End of the received data packet |
| txValid | output | 1 | Transmit byte valid |
| txByte | output | 8 | Transmit byte |
| txLast | output | 1 | Final transmit byte |
| txToggle | output | 1 | Toggle of the transmitted data packet |
| hsValid | output | 1 | Response strobe |
| hsCode | output | 2 | Response: 0 ACK, 1 NAK, 2 STALL, 3 none |

## Verification
The properties assume that the CPU loads the descriptor only while no token is in progress, and that tokens arrive at least two cycles apart. Without these, a response and a descriptor update could overlap and the stability checks on stall and ignore would not be meaningful. The stimulus loads the descriptor and finishes each write before the next token. It waits out the whole response pulse before the next transaction, and it never raises rxValid and rxEnd in the same cycle.

// File: rtl/ep_desc_pkg.sv
package ep_desc_pkg;
  localparam int CNT_W = 10;
  localparam int ST_W  = 6;

  // status word bit positions
  localparam int B_OWN   = 0;
  localparam int B_TGL   = 1;
  localparam int B_CHK   = 2;
  localparam int B_STALL = 3;
  localparam int B_KEEP  = 4;
  localparam int B_INCD  = 5;

  typedef enum logic [1:0] {
    TK_OUT   = 2'd0,
    TK_IN    = 2'd1,
    TK_SETUP = 2'd2,
    TK_RSVD  = 2'd3
  } tokKind_e;

  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2,
    HS_NONE  = 2'd3
  } hsCode_e;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_RX   = 2'd1,
    CS_TX   = 2'd2
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPtr;
    logic step;
    logic wrMem;
    logic setOvf;
    logic clrOvf;
    logic saveCnt;
  } dpStrobe_t;
endpackage

// File: rtl/ep_desc_ctrl.sv
module ep_desc_ctrl
  import ep_desc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cpuWe,
  input  logic [ST_W-1:0]       cpuStat,
  input  logic                  tokValid,
  input  logic [1:0]            tokKind,
  input  logic                  tokToggle,
  input  logic                  rxValid,
  input  logic                  rxEnd,
  input  logic [CNT_W-1:0]      xferCnt,
  input  logic [CNT_W-1:0]      cntReg,
  output logic [ST_W-1:0]       statOut,
  output logic [1:0]            lastPid,
  output logic                  hsValid,
  output logic [1:0]            hsCode,
  output logic                  txValid,
  output logic                  txLast,
  output logic                  txToggle,
  output dpStrobe_t             strobe
);
  ctrlState_e state;
  hsCode_e    mode;
  hsCode_e    rxMode;
  tokKind_e   tokKindE;
  tokKind_e   curKind;
  logic       curTgl;
  logic       own, tgl, chk, stall, keep, incDis;
  logic       cntDone;

  assign tokKindE = tokKind_e'(tokKind);
  assign statOut  = {incDis, keep, stall, chk, tgl, own};
  assign cntDone  = (xferCnt == cntReg);
  assign txValid  = (state == CS_TX) && !cntDone;
  assign txLast   = txValid && ((xferCnt + CNT_W'(1)) == cntReg);
  assign txToggle = tgl;

  // response chosen for an OUT or SETUP token
  always_comb begin
    if (!own)
      rxMode = HS_NAK;
    else if (stall)
      rxMode = HS_STALL;
    else if (chk && (tokKindE == TK_OUT) && (tokToggle != tgl))
      rxMode = HS_NONE;
    else
      rxMode = HS_ACK;
  end

  always_comb begin
    strobe = '0;
    unique case (state)
      CS_IDLE: begin
        if (tokValid && (tokKindE != TK_RSVD)) begin
          strobe.clrOvf  = 1'b1;
          strobe.loadPtr = 1'b1;
        end
      end
      CS_RX: begin
        if (rxValid && (mode == HS_ACK)) begin
          if (xferCnt < cntReg) begin
            strobe.wrMem = 1'b1;
            strobe.step  = 1'b1;
          end else begin
            strobe.setOvf = 1'b1;
          end
        end
        if (rxEnd && (mode == HS_ACK) && !keep)
          strobe.saveCnt = 1'b1;
      end
      CS_TX: begin
        if (!cntDone)
          strobe.step = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= CS_IDLE;
      mode    <= HS_ACK;
      curKind <= TK_OUT;
      curTgl  <= 1'b0;
      own     <= 1'b0;
      tgl     <= 1'b0;
      chk     <= 1'b0;
      stall   <= 1'b0;
      keep    <= 1'b0;
      incDis  <= 1'b0;
      lastPid <= 2'd0;
      hsValid <= 1'b0;
      hsCode  <= 2'd0;
    end else begin
      hsValid <= 1'b0;
      if (cpuWe) begin
        own    <= cpuStat[B_OWN];
        tgl    <= cpuStat[B_TGL];
        chk    <= cpuStat[B_CHK];
        stall  <= cpuStat[B_STALL];
        keep   <= cpuStat[B_KEEP];
        incDis <= cpuStat[B_INCD];
      end
      unique case (state)
        CS_IDLE: begin
          if (tokValid) begin
            curKind <= tokKindE;
            curTgl  <= tokToggle;
            unique case (tokKindE)
              TK_OUT, TK_SETUP: begin
                mode  <= rxMode;
                state <= CS_RX;
              end
              TK_IN: begin
                if (!own) begin
                  hsValid <= 1'b1;
                  hsCode  <= HS_NAK;
                end else if (stall) begin
                  hsValid <= 1'b1;
                  hsCode  <= HS_STALL;
                end else begin
                  state <= CS_TX;
                end
              end
              default: ;
            endcase
          end
        end
        CS_RX: begin
          if (rxEnd) begin
            hsValid <= 1'b1;
            hsCode  <= mode;
            state   <= CS_IDLE;
            if ((mode == HS_ACK) && !keep) begin
              own     <= 1'b0;
              tgl     <= curTgl;
              lastPid <= curKind;
            end
          end
        end
        CS_TX: begin
          if (cntDone) begin
            hsValid <= 1'b1;
            hsCode  <= HS_ACK;
            state   <= CS_IDLE;
            if (!keep) begin
              own     <= 1'b0;
              lastPid <= TK_IN;
            end
          end
        end
        default: state <= CS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ep_desc_dpath.sv
module ep_desc_dpath
  import ep_desc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuWe,
  input  logic [AW-1:0]    cpuAddr,
  input  logic [CNT_W-1:0] cpuCnt,
  input  logic             incDis,
  input  dpStrobe_t        strobe,
  input  logic [7:0]       rxByte,
  input  logic             cpuMemWe,
  input  logic [AW-1:0]    cpuMemAddr,
  input  logic [7:0]       cpuMemWdata,
  output logic [7:0]       cpuMemRdata,
  output logic [7:0]       txByte,
  output logic [AW-1:0]    addrOut,
  output logic [CNT_W-1:0] cntReg,
  output logic [CNT_W-1:0] xferCnt,
  output logic             ovfOut
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] ptr;
  logic [AW-1:0] addrReg;

  assign addrOut     = addrReg;
  assign txByte      = mem[ptr];
  assign cpuMemRdata = mem[cpuMemAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      cntReg  <= '0;
      ptr     <= '0;
      xferCnt <= '0;
      ovfOut  <= 1'b0;
    end else begin
      if (cpuWe) begin
        addrReg <= cpuAddr;
        cntReg  <= cpuCnt;
      end
      if (strobe.saveCnt)
        cntReg <= xferCnt;
      if (strobe.loadPtr) begin
        ptr     <= addrReg;
        xferCnt <= '0;
      end else if (strobe.step) begin
        ptr     <= incDis ? ptr : ptr + AW'(1);
        xferCnt <= xferCnt + CNT_W'(1);
      end
      if (strobe.clrOvf)
        ovfOut <= 1'b0;
      else if (strobe.setOvf)
        ovfOut <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrMem)
      mem[ptr] <= rxByte;
    else if (cpuMemWe)
      mem[cpuMemAddr] <= cpuMemWdata;
  end
endmodule

// File: rtl/ep_desc_engine.sv
module ep_desc_engine
  import ep_desc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuWe,
  input  logic [ST_W-1:0]  cpuStat,
  input  logic [AW-1:0]    cpuAddr,
  input  logic [CNT_W-1:0] cpuCnt,
  output logic [ST_W-1:0]  statOut,
  output logic [AW-1:0]    addrOut,
  output logic [CNT_W-1:0] cntOut,
  output logic [1:0]       lastPid,
  output logic             ovfOut,
  input  logic             cpuMemWe,
  input  logic [AW-1:0]    cpuMemAddr,
  input  logic [7:0]       cpuMemWdata,
  output logic [7:0]       cpuMemRdata,
  input  logic             tokValid,
  input  logic [1:0]       tokKind,
  input  logic             tokToggle,
  input  logic             rxValid,
  input  logic [7:0]       rxByte,
  input  logic             rxEnd,
  output logic             txValid,
  output logic [7:0]       txByte,
  output logic             txLast,
  output logic             txToggle,
  output logic             hsValid,
  output logic [1:0]       hsCode
);
  dpStrobe_t        strobe;
  logic [CNT_W-1:0] xferCnt;

  ep_desc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuWe    (cpuWe),
    .cpuStat  (cpuStat),
    .tokValid (tokValid),
    .tokKind  (tokKind),
    .tokToggle(tokToggle),
    .rxValid  (rxValid),
    .rxEnd    (rxEnd),
    .xferCnt  (xferCnt),
    .cntReg   (cntOut),
    .statOut  (statOut),
    .lastPid  (lastPid),
    .hsValid  (hsValid),
    .hsCode   (hsCode),
    .txValid  (txValid),
    .txLast   (txLast),
    .txToggle (txToggle),
    .strobe   (strobe)
  );

  ep_desc_dpath #(.AW(AW)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .cpuWe      (cpuWe),
    .cpuAddr    (cpuAddr),
    .cpuCnt     (cpuCnt),
    .incDis     (statOut[B_INCD]),
    .strobe     (strobe),
    .rxByte     (rxByte),
    .cpuMemWe   (cpuMemWe),
    .cpuMemAddr (cpuMemAddr),
    .cpuMemWdata(cpuMemWdata),
    .cpuMemRdata(cpuMemRdata),
    .txByte     (txByte),
    .addrOut    (addrOut),
    .cntReg     (cntOut),
    .xferCnt    (xferCnt),
    .ovfOut     (ovfOut)
  );
endmodule

// File: rtl/ep_desc_engine_chk.sv
module ep_desc_engine_chk (
  input logic       clk,
  input logic       rstN,
  input logic [5:0] statOut,
  input logic [9:0] cntOut,
  input logic       hsValid,
  input logic [1:0] hsCode,
  input logic       txValid
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsValid && hsCode == 2'd2) |-> (statOut[0] && $stable(statOut) && $stable(cntOut)));

  // R5
  ignore_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsValid && hsCode == 2'd3) |-> (statOut[0] && $stable(statOut) && $stable(cntOut)));

  // R2
  nak_unowned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsValid && hsCode == 2'd1) |-> !statOut[0]);

  // R11
  tx_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (statOut[0] && !statOut[3]));

  // R9
  keep_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsValid && hsCode == 2'd0 && statOut[4]) |-> statOut[0]);

  // R4
  handback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsValid && hsCode == 2'd0 && !statOut[4]) |-> !statOut[0]);

  // R13
  hs_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    hsValid |=> !hsValid);
endmodule

bind ep_desc_engine ep_desc_engine_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .statOut(statOut),
  .cntOut (cntOut),
  .hsValid(hsValid),
  .hsCode (hsCode),
  .txValid(txValid)
);

// File: tb/ep_desc_engine_bench.sv
module ep_desc_engine_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic       cpuWe;
  logic [5:0] cpuStat;
  logic [7:0] cpuAddr;
  logic [9:0] cpuCnt;
  logic [5:0] statOut;
  logic [7:0] addrOut;
  logic [9:0] cntOut;
  logic [1:0] lastPid;
  logic       ovfOut;
  logic       cpuMemWe;
  logic [7:0] cpuMemAddr;
  logic [7:0] cpuMemWdata;
  logic [7:0] cpuMemRdata;
  logic       tokValid;
  logic [1:0] tokKind;
  logic       tokToggle;
  logic       rxValid;
  logic [7:0] rxByte;
  logic       rxEnd;
  logic       txValid;
  logic [7:0] txByte;
  logic       txLast;
  logic       txToggle;
  logic       hsValid;
  logic [1:0] hsCode;

  ep_desc_engine u_ep_desc_engine (.*);

  always #4 clk = ~clk;

  int totalCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  logic [7:0] shadow [256];
  logic [5:0] expStat;
  logic [7:0] expAddr;
  logic [9:0] expCnt;
  logic [1:0] expPid;
  logic       expOvf;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeDesc(input logic [5:0] st, input logic [7:0] a, input logic [9:0] c);
    @(negedge clk);
    cpuWe = 1'b1; cpuStat = st; cpuAddr = a; cpuCnt = c;
    @(negedge clk);
    cpuWe = 1'b0;
    expStat = st; expAddr = a; expCnt = c;
  endtask

  task automatic memPoke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuMemWe = 1'b1; cpuMemAddr = a; cpuMemWdata = d;
    @(negedge clk);
    cpuMemWe = 1'b0;
    shadow[a] = d;
  endtask

  task automatic checkDesc(input string tag);
    check({tag, " status"}, 32'(statOut), 32'(expStat));
    check({tag, " count"},  32'(cntOut),  32'(expCnt));
    check({tag, " addr"},   32'(addrOut), 32'(expAddr));
    check({tag, " pid"},    32'(lastPid), 32'(expPid));
    check({tag, " ovf"},    32'(ovfOut),  32'(expOvf));
  endtask

  task automatic checkMemRange(input string tag, input logic [7:0] a, input int n);
    for (int i = -1; i <= n + 1; i++) begin
      cpuMemAddr = 8'(int'(a) + i);
      #1;
      check({tag, " mem"}, 32'(cpuMemRdata), 32'(shadow[cpuMemAddr]));
    end
  endtask

  // reference model and driver for an OUT or SETUP packet
  task automatic runOut(input string tag, input logic [1:0] kind, input logic tg,
                        input int n, input logic [7:0] seed);
    logic [1:0] expHs;
    logic [7:0] a;
    expOvf = 1'b0;
    if (!expStat[0])                            expHs = 2'd1;
    else if (expStat[3])                        expHs = 2'd2;
    else if (expStat[2] && kind == 2'd0 && tg != expStat[1]) expHs = 2'd3;
    else                                        expHs = 2'd0;
    if (expHs == 2'd0) begin
      a = expAddr;
      for (int i = 0; i < n; i++) begin
        if (i < int'(expCnt)) begin
          shadow[a] = 8'(int'(seed) + i);
          if (!expStat[5]) a = a + 8'd1;
        end else expOvf = 1'b1;
      end
      if (!expStat[4]) begin
        expStat[0] = 1'b0;
        expStat[1] = tg;
        expCnt = (n < int'(expCnt)) ? 10'(n) : expCnt;
        expPid = kind;
      end
    end
    @(negedge clk);
    tokValid = 1'b1; tokKind = kind; tokToggle = tg;
    @(negedge clk);
    tokValid = 1'b0;
    for (int i = 0; i < n; i++) begin
      rxValid = 1'b1; rxByte = 8'(int'(seed) + i);
      @(negedge clk);
    end
    rxValid = 1'b0; rxEnd = 1'b1;
    @(negedge clk);
    rxEnd = 1'b0;
    check({tag, " hsValid"}, 32'(hsValid), 32'd1);
    check({tag, " hsCode"},  32'(hsCode),  32'(expHs));
    checkDesc(tag);
    @(negedge clk);
    check({tag, " R13 pulse"}, 32'(hsValid), 32'd0);
    checkMemRange(tag, expAddr, n);
  endtask

  // reference model and driver for an IN token
  task automatic runIn(input string tag);
    logic [1:0] expHs;
    logic [5:0] st0;
    int expN;
    int idx;
    st0 = expStat;
    expOvf = 1'b0;
    if (!expStat[0])      expHs = 2'd1;
    else if (expStat[3])  expHs = 2'd2;
    else                  expHs = 2'd0;
    expN = (expHs == 2'd0) ? int'(expCnt) : 0;
    if (expHs == 2'd0 && !expStat[4]) begin
      expStat[0] = 1'b0;
      expPid = 2'd1;
    end
    @(negedge clk);
    tokValid = 1'b1; tokKind = 2'd1; tokToggle = 1'b0;
    @(negedge clk);
    tokValid = 1'b0;
    idx = 0;
    for (int g = 0; g < 2000; g++) begin
      if (hsValid) break;
      if (txValid) begin
        check({tag, " byte"}, 32'(txByte),
              32'(shadow[8'(int'(expAddr) + (st0[5] ? 0 : idx))]));
        check({tag, " last"}, 32'(txLast), 32'(idx == expN - 1));
        check({tag, " toggle"}, 32'(txToggle), 32'(st0[1]));
        idx++;
      end
      @(negedge clk);
    end
    check({tag, " nbytes"}, 32'(idx), 32'(expN));
    check({tag, " hsValid"}, 32'(hsValid), 32'd1);
    check({tag, " hsCode"}, 32'(hsCode), 32'(expHs));
    checkDesc(tag);
    @(negedge clk);
    check({tag, " R13 pulse"}, 32'(hsValid), 32'd0);
  endtask

  task automatic tReset();
    check("R1 status", 32'(statOut), 32'd0);
    check("R1 count",  32'(cntOut),  32'd0);
    check("R1 addr",   32'(addrOut), 32'd0);
    check("R1 pid",    32'(lastPid), 32'd0);
    check("R1 ovf",    32'(ovfOut),  32'd0);
    check("R1 hs",     32'(hsValid), 32'd0);
    check("R1 tx",     32'(txValid), 32'd0);
  endtask

  task automatic tNak();
    writeDesc(6'h00, 8'h10, 10'd4);
    runOut("R2 out nak", 2'd0, 1'b0, 4, 8'hA0);
    runIn("R2 in nak");
  endtask

  task automatic tOutBasic();
    writeDesc(6'h05, 8'h20, 10'd8);
    runOut("R3 R4 out data0", 2'd0, 1'b0, 5, 8'h30);
    writeDesc(6'h07, 8'h40, 10'd8);
    runOut("R3 R4 out data1", 2'd0, 1'b1, 3, 8'h60);
  endtask

  task automatic tMismatch();
    writeDesc(6'h05, 8'h48, 10'd8);
    runOut("R5 toggle mismatch", 2'd0, 1'b1, 4, 8'h11);
  endtask

  task automatic tSetup();
    writeDesc(6'h05, 8'h28, 10'd8);
    runOut("R6 setup mismatch", 2'd2, 1'b1, 3, 8'h50);
  endtask

  task automatic tChkOff();
    writeDesc(6'h01, 8'h50, 10'd8);
    runOut("R7 no check", 2'd0, 1'b1, 2, 8'h77);
  endtask

  task automatic tStall();
    writeDesc(6'h09, 8'h58, 10'd6);
    runOut("R8 stall out", 2'd0, 1'b0, 4, 8'h22);
    runIn("R8 stall in");
  endtask

  task automatic tKeep();
    writeDesc(6'h11, 8'h30, 10'd6);
    runOut("R9 keep first", 2'd0, 1'b1, 4, 8'h80);
    runOut("R9 keep second", 2'd0, 1'b0, 3, 8'h88);
    runIn("R9 keep in");
  endtask

  task automatic tIncDis();
    writeDesc(6'h21, 8'h38, 10'd4);
    runOut("R10 out fixed", 2'd0, 1'b0, 4, 8'h70);
    writeDesc(6'h21, 8'h38, 10'd3);
    runIn("R10 in fixed");
  endtask

  task automatic tIn();
    writeDesc(6'h03, 8'h20, 10'd5);
    runIn("R11 in data1");
    writeDesc(6'h01, 8'h60, 10'd0);
    runIn("R11 in zero length");
  endtask

  task automatic tOverflow();
    writeDesc(6'h01, 8'h3C, 10'd2);
    runOut("R12 overflow", 2'd0, 1'b0, 5, 8'h90);
    writeDesc(6'h00, 8'h3C, 10'd2);
    runIn("R12 ovf cleared");
  endtask

  initial begin
    rstN = 1'b0; cpuWe = 1'b0; cpuStat = '0; cpuAddr = '0; cpuCnt = '0;
    cpuMemWe = 1'b0; cpuMemAddr = '0; cpuMemWdata = '0;
    tokValid = 1'b0; tokKind = '0; tokToggle = 1'b0;
    rxValid = 1'b0; rxByte = '0; rxEnd = 1'b0;
    expStat = '0; expAddr = '0; expCnt = '0; expPid = '0; expOvf = 1'b0;
    for (int i = 0; i < 256; i++) shadow[i] = 8'hxx;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    for (int i = 0; i < 128; i++) memPoke(8'(i), 8'(8'hC3 ^ i));
    tNak();
    tOutBasic();
    tMismatch();
    tSetup();
    tChkOff();
    tStall();
    tKeep();
    tIncDis();
    tIn();
    tOverflow();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      totalCnt++;
      failCnt++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end
endmodule